// File: doc/BRIEF.md
# Bit and Baud Clock Generator

This block derives two modem timing clocks for one signal direction, a bit-rate clock and a baud-rate clock, from a 13.824 MHz master clock. A 4-bit code picks the bit rate and a 3-bit code picks the baud rate. A scaling flag raises every rate by a factor of 8/7, except one bit-rate code that is exempt. Each output comes from a master-clock divider. Its period in master cycles is the master frequency divided by the selected rate.

The block stays locked to the conversion clock of its direction through an alignment strobe. A strobe restarts both dividers, so each output starts a fresh high phase in the same cycle. The strobe is also the only moment at which new codes and a new scaling flag are taken in. A code change between strobes therefore never cuts a pulse short. Reserved codes hold their output low.

Top module: `bbclk_gen`

## Requirements
- R1: Bit-rate codes select these periods in master cycles: 0000→1440 (9600 Hz), 0001→1728 (8000 Hz), 0010→1920 (7200 Hz), 0011→2880 (4800 Hz), 0100→5760 (2400 Hz), 0101→11520 (1200 Hz), 0110→23040 (600 Hz), 0111→720 (19200 Hz), 1000→960 (14400 Hz), 1001→1152 (12000 Hz).
- R2: Bit-rate code 1010 gives a period of 720 cycles (19200 Hz) whether or not the 8/7 flag is set.
- R3: Bit-rate codes 1011 to 1111 are reserved, and with them the bit clock stays low.
- R4: Baud-rate codes 000→5760 (2400 Hz), 001→8640 (1600 Hz), 010→11520 (1200 Hz), 011→23040 (600 Hz); codes 100 to 111 are reserved and hold the baud clock low.
- R5: Each output is high for half of its period. The 1600 Hz baud rate is the exception: it is high for one third of its period (2880 of 8640 cycles).
- R6: With the 8/7 flag set, every period and every high time except that of code 1010 is multiplied by 7/8 (for example 1440→1260 and 8640→7560 with 2520 high).
- R7: An alignment strobe sampled at a clock edge restarts both dividers. Each output with a valid code is high in the cycle after that edge and begins a full period there.
- R8: Codes and the 8/7 flag are captured only at an alignment strobe. A change between strobes leaves both outputs unchanged.
- R9: After reset the captured settings are bit code 0000, baud code 000 and no scaling. Both dividers start from phase zero with these settings, whatever the inputs are, until the first strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock (13.824 MHz nominal) |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_rate_sel | input | 4 | Bit-rate code, captured at a strobe |
| baud_rate_sel | input | 3 | Baud-rate code, captured at a strobe |
| rate_8_7 | input | 1 | 8/7 rate scaling flag, captured at a strobe |
| conv_align | input | 1 | One-cycle alignment strobe from the conversion clock |
| bit_clk | output | 1 | Bit-rate clock |
| baud_clk | output | 1 | Baud-rate clock |

## Verification
The divider checks rely on the captured period and high time staying constant between strobes. They also rely on every decoded valid high time lying strictly between zero and the period, and the embedded properties check both of these. The stimulus changes codes and the flag only at negative edges. It raises the strobe for exactly one cycle, and during each measured period it leaves the strobe low, so a full period can be counted from restart to the next rising edge. The change-between-strobes case alters the inputs directly after a strobe and then measures the running clocks before the next strobe.

// File: rtl/bbclk_pkg.sv
// Shared widths and the captured-configuration type for the bit/baud
// clock generator. Assumes the bit code is at least as wide as the baud code.
package bbclk_pkg;
    localparam int unsigned BBC_BIT_SEL_W  = 4;
    localparam int unsigned BBC_BAUD_SEL_W = 3;

    typedef struct packed {
        logic [BBC_BIT_SEL_W-1:0]  bit_code;
        logic [BBC_BAUD_SEL_W-1:0] baud_code;
        logic                      scale;
    } bbc_cfg_t;

    localparam bbc_cfg_t BBC_CFG_DEFAULT = '0;
endpackage

// File: rtl/bbclk_cfg_latch.sv
// Holds the rate codes and the scaling flag. New values are taken only
// when load is high, so the dividers see stable settings between
// alignment strobes. Assumes load is a single-cycle strobe.
module bbclk_cfg_latch
    import bbclk_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load,
    input  bbc_cfg_t d,
    output bbc_cfg_t q
);

    // Capture settings on a strobe; defaults after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= BBC_CFG_DEFAULT;
        end else if (load) begin
            q <= d;
        end
    end

    // R8: settings hold between strobes.
    p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q));

    // R8: a strobe takes in exactly the presented settings.
    p_cfg_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (q == $past(d)));

endmodule

// File: rtl/bbclk_rate_decode.sv
// Maps a rate code to a divider period and high time, in master cycles.
// IS_BAUD selects the baud table; otherwise the bit table is built.
// Scaling by 7/8 uses shift-and-subtract; it assumes every base period
// and high time is a multiple of 8, which holds at 13.824 MHz.
module bbclk_rate_decode #(
    parameter int unsigned MCLK_HZ = 13824000,
    parameter int unsigned CNT_W   = 15,
    parameter int unsigned SEL_W   = 4,
    parameter bit          IS_BAUD = 1'b0
) (
    input  logic [SEL_W-1:0] code,
    input  logic             scale,
    output logic             valid,
    output logic [CNT_W-1:0] tc,
    output logic [CNT_W-1:0] hi
);

    localparam int unsigned EXT_W = CNT_W + 3;

    logic [CNT_W-1:0] base_tc;
    logic [CNT_W-1:0] base_hi;
    logic             third;
    logic             exempt;
    logic [EXT_W-1:0] tc_x7;
    logic [EXT_W-1:0] hi_x7;

    generate
        if (IS_BAUD) begin : g_baud
            // Baud table: four rates, the rest reserved.
            always_comb begin
                valid   = 1'b1;
                base_tc = '0;
                third   = 1'b0;
                exempt  = 1'b0;
                case (code)
                    SEL_W'(0): base_tc = CNT_W'(MCLK_HZ / 2400);
                    SEL_W'(1): begin
                        base_tc = CNT_W'(MCLK_HZ / 1600);
                        third   = 1'b1;
                    end
                    SEL_W'(2): base_tc = CNT_W'(MCLK_HZ / 1200);
                    SEL_W'(3): base_tc = CNT_W'(MCLK_HZ / 600);
                    default:   valid   = 1'b0;
                endcase
            end
        end else begin : g_bit
            // Bit table: eleven rates, one exempt from scaling.
            always_comb begin
                valid   = 1'b1;
                base_tc = '0;
                third   = 1'b0;
                exempt  = 1'b0;
                case (code)
                    SEL_W'(0):  base_tc = CNT_W'(MCLK_HZ / 9600);
                    SEL_W'(1):  base_tc = CNT_W'(MCLK_HZ / 8000);
                    SEL_W'(2):  base_tc = CNT_W'(MCLK_HZ / 7200);
                    SEL_W'(3):  base_tc = CNT_W'(MCLK_HZ / 4800);
                    SEL_W'(4):  base_tc = CNT_W'(MCLK_HZ / 2400);
                    SEL_W'(5):  base_tc = CNT_W'(MCLK_HZ / 1200);
                    SEL_W'(6):  base_tc = CNT_W'(MCLK_HZ / 600);
                    SEL_W'(7):  base_tc = CNT_W'(MCLK_HZ / 19200);
                    SEL_W'(8):  base_tc = CNT_W'(MCLK_HZ / 14400);
                    SEL_W'(9):  base_tc = CNT_W'(MCLK_HZ / 12000);
                    SEL_W'(10): begin
                        base_tc = CNT_W'(MCLK_HZ / 19200);
                        exempt  = 1'b1;
                    end
                    default:    valid = 1'b0;
                endcase
            end
        end
    endgenerate

    // High time: one third for the 1600 Hz rate, half otherwise.
    assign base_hi = third ? CNT_W'(MCLK_HZ / (1600 * 3)) : (base_tc >> 1);

    // Times seven by shift-and-subtract; the later >>3 completes 7/8.
    assign tc_x7 = ({3'b000, base_tc} << 3) - {3'b000, base_tc};
    assign hi_x7 = ({3'b000, base_hi} << 3) - {3'b000, base_hi};

    assign tc = (scale && !exempt) ? tc_x7[EXT_W-1:3] : base_tc;
    assign hi = (scale && !exempt) ? hi_x7[EXT_W-1:3] : base_hi;

endmodule

// File: rtl/bbclk_divider.sv
// Master-clock divider with restart. The output is high while the count
// is below the high time. Assumes valid, tc and hi change only in the
// cycle that follows a restart.
module bbclk_divider #(
    parameter int unsigned CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             valid,
    input  logic [CNT_W-1:0] tc,
    input  logic [CNT_W-1:0] hi,
    output logic             clk_out
);

    logic [CNT_W-1:0] cnt;

    // Count through one period; restart, reserved code or reset clear it.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !valid) begin
            cnt <= '0;
        end else if (cnt >= tc - CNT_W'(1)) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    // Output phase from the count.
    assign clk_out = valid && (cnt < hi);

    // R1: the count never leaves the selected period.
    p_cnt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (cnt < tc));

    // R1: the last count of a period wraps to zero.
    p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !restart && (cnt == tc - CNT_W'(1))) |=> (cnt == '0));

    // R5: the decoded high time lies inside the period.
    p_hi_inside_r5: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> ((hi != '0) && (hi < tc)));

    // R7: after a restart a valid output begins its high phase.
    p_restart_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (clk_out || !valid));

endmodule

// File: rtl/bbclk_gen.sv
// Bit and baud clock generator for one direction. Captures the rate
// codes and the 8/7 flag on each alignment strobe and restarts both
// dividers there. Assumes conv_align is synchronous to mclk and one
// cycle wide.
module bbclk_gen
    import bbclk_pkg::*;
#(
    parameter int unsigned MCLK_HZ     = 13824000,
    parameter int unsigned MIN_RATE_HZ = 600
) (
    input  logic                      mclk,
    input  logic                      rst_n,
    input  logic [BBC_BIT_SEL_W-1:0]  bit_rate_sel,
    input  logic [BBC_BAUD_SEL_W-1:0] baud_rate_sel,
    input  logic                      rate_8_7,
    input  logic                      conv_align,
    output logic                      bit_clk,
    output logic                      baud_clk
);

    localparam int unsigned CNT_W  = $clog2(MCLK_HZ / MIN_RATE_HZ + 1);
    localparam int unsigned CODE_W = BBC_BIT_SEL_W;
    localparam int unsigned N_CH   = 2;

    bbc_cfg_t         cfg_in;
    bbc_cfg_t         cfg_q;
    logic [CODE_W-1:0] code_ch [N_CH];
    logic [N_CH-1:0]  ch_out;

    assign cfg_in.bit_code  = bit_rate_sel;
    assign cfg_in.baud_code = baud_rate_sel;
    assign cfg_in.scale     = rate_8_7;

    bbclk_cfg_latch u_cfg (
        .clk   (mclk),
        .rst_n (rst_n),
        .load  (conv_align),
        .d     (cfg_in),
        .q     (cfg_q)
    );

    assign code_ch[0] = cfg_q.bit_code;
    assign code_ch[1] = CODE_W'(cfg_q.baud_code);

    generate
        for (genvar g = 0; g < N_CH; g++) begin : g_ch
            logic             valid;
            logic [CNT_W-1:0] tc;
            logic [CNT_W-1:0] hi;

            bbclk_rate_decode #(
                .MCLK_HZ (MCLK_HZ),
                .CNT_W   (CNT_W),
                .SEL_W   (CODE_W),
                .IS_BAUD (g == 1)
            ) u_dec (
                .code  (code_ch[g]),
                .scale (cfg_q.scale),
                .valid (valid),
                .tc    (tc),
                .hi    (hi)
            );

            bbclk_divider #(
                .CNT_W (CNT_W)
            ) u_div (
                .clk     (mclk),
                .rst_n   (rst_n),
                .restart (conv_align),
                .valid   (valid),
                .tc      (tc),
                .hi      (hi),
                .clk_out (ch_out[g])
            );
        end
    endgenerate

    assign bit_clk  = ch_out[0];
    assign baud_clk = ch_out[1];

endmodule

// File: tb/tb_bbclk_gen.sv
module tb_bbclk_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bit_sel = '0;
    logic [2:0] baud_sel = '0;
    logic       scale = 1'b0;
    logic       align = 1'b0;
    logic       bit_clk;
    logic       baud_clk;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    bbclk_gen dut (
        .mclk          (clk),
        .rst_n         (rst_n),
        .bit_rate_sel  (bit_sel),
        .baud_rate_sel (baud_sel),
        .rate_8_7      (scale),
        .conv_align    (align),
        .bit_clk       (bit_clk),
        .baud_clk      (baud_clk)
    );

    // Vectors: scale, bit code, baud code, bit high, bit period,
    // baud high, baud period (period 0 = reserved, output must stay low).
    localparam int NROW = 17;
    localparam int T_SC [NROW] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 1, 1, 0, 1};
    localparam int T_B  [NROW] = '{0, 1, 2, 6, 4, 5, 3, 7, 8, 9, 10, 0, 10, 7, 8, 11, 15};
    localparam int T_D  [NROW] = '{0, 1, 4, 3, 5, 6, 7, 2, 0, 1, 0, 1, 0, 3, 2, 0, 4};
    localparam int T_BH [NROW] = '{720, 864, 960, 11520, 2880, 5760, 1440, 360, 480, 576,
                                   360, 630, 360, 315, 420, 0, 0};
    localparam int T_BP [NROW] = '{1440, 1728, 1920, 23040, 5760, 11520, 2880, 720, 960, 1152,
                                   720, 1260, 720, 630, 840, 0, 0};
    localparam int T_DH [NROW] = '{2880, 2880, 0, 11520, 0, 0, 0, 5760, 2880, 2880,
                                   2880, 2520, 2520, 10080, 5040, 2880, 0};
    localparam int T_DP [NROW] = '{5760, 8640, 0, 23040, 0, 0, 0, 11520, 5760, 8640,
                                   5760, 7560, 5040, 20160, 10080, 5760, 0};

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // mode 0: strobe then measure; mode 1: measure from reset release.
    task automatic run(input int mode, input int sc, input int b, input int d,
                       input int ebh, input int ebp, input int edh, input int edp,
                       input int swp, input int sc2, input int b2, input int d2,
                       input string tag);
        int bhi = 0, blo = 0, bph = 0, bseen = 0, bfirst = 0;
        int dhi = 0, dlo = 0, dph = 0, dseen = 0, dfirst = 0;
        bit bdone = 1'b0, ddone = 1'b0;
        int n = 0;
        int v, w;
        string bt, dt;
        @(negedge clk);
        bit_sel  = 4'(b);
        baud_sel = 3'(d);
        scale    = sc[0];
        if (mode == 0) begin
            align = 1'b1;
            @(negedge clk);
            align = 1'b0;
        end else begin
            rst_n = 1'b0;
            repeat (3) @(negedge clk);
        end
        bfirst = int'(bit_clk);
        dfirst = int'(baud_clk);
        while (n < 30000) begin
            v = int'(bit_clk);
            w = int'(baud_clk);
            if (!bdone) begin
                if (ebp == 0) begin
                    bseen = bseen | v;
                    if (n >= 1000) bdone = 1'b1;
                end else if (bph == 0) begin
                    if (v == 1) bhi++; else begin bph = 1; blo++; end
                end else begin
                    if (v == 0) blo++; else bdone = 1'b1;
                end
            end
            if (!ddone) begin
                if (edp == 0) begin
                    dseen = dseen | w;
                    if (n >= 1000) ddone = 1'b1;
                end else if (dph == 0) begin
                    if (w == 1) dhi++; else begin dph = 1; dlo++; end
                end else begin
                    if (w == 0) dlo++; else ddone = 1'b1;
                end
            end
            if (n == 0) begin
                if (mode == 1) rst_n = 1'b1;
                if (swp != 0) begin
                    bit_sel  = 4'(b2);
                    baud_sel = 3'(d2);
                    scale    = sc2[0];
                end
            end
            if (bdone && ddone) break;
            @(negedge clk);
            n++;
        end
        if (tag != "") begin
            bt = tag;
            dt = tag;
        end else begin
            bt = (ebp == 0) ? "R3" : (b == 10) ? "R2" : (sc != 0) ? "R6" : "R1";
            dt = (edp == 0) ? "R4" : (d == 1) ? "R5" : (sc != 0) ? "R6" : "R4";
        end
        if (ebp == 0) begin
            check(bseen == 0, bt, "bit clock high on reserved code", bseen, 0);
        end else begin
            check(bhi == ebh, "R5", "bit clock high time", bhi, ebh);
            check(bhi + blo == ebp, bt, "bit clock period", bhi + blo, ebp);
            if (mode == 0) check(bfirst == 1, "R7", "bit clock high after strobe", bfirst, 1);
        end
        if (edp == 0) begin
            check(dseen == 0, dt, "baud clock high on reserved code", dseen, 0);
        end else begin
            check(dhi == edh, "R5", "baud clock high time", dhi, edh);
            check(dhi + dlo == edp, dt, "baud clock period", dhi + dlo, edp);
            if (mode == 0) check(dfirst == 1, "R7", "baud clock high after strobe", dfirst, 1);
        end
    endtask

    initial begin
        // R9: nonzero inputs during and after reset are ignored; defaults run.
        run(1, 1, 7, 3, 720, 1440, 2880, 5760, 0, 0, 0, 0, "R9");

        // Table walk: R1 R2 R3 R4 R5 R6 R7.
        for (int i = 0; i < NROW; i++) begin
            run(0, T_SC[i], T_B[i], T_D[i], T_BH[i], T_BP[i], T_DH[i], T_DP[i],
                0, 0, 0, 0, "");
        end

        // R8: change inputs right after a strobe; running clocks keep old rates.
        run(0, 0, 7, 0, 360, 720, 2880, 5760, 1, 1, 0, 1, "R8");
        // R8: the next strobe takes in the new settings.
        run(0, 1, 0, 1, 630, 1260, 2520, 7560, 0, 0, 0, 0, "R8");

        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (198000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL timeout: actual %0d cycles expected completion", 198000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule